// File: doc/BRIEF.md
# Serial Word Loader for Latched Sink Driver Chains

This block runs on the host side and writes one parallel word into a chain of serial-input latched sink drivers. A one-cycle start request in the idle state captures the word. The block then moves the word out one bit at a time on a serial data line, with a shift clock that it generates. After the last bit it raises a strobe, which copies the shift-register contents into the driver latches. It then signals completion.

All driver-side timing comes from the system clock. Each minimum time is given in picoseconds. It is turned into a whole number of system-clock cycles, rounded up, with a floor of one cycle. These times are:

- data setup before the shift-clock rise
- data hold after the shift-clock rise
- shift-clock high width
- gap between the final shift clock and the strobe
- strobe width

The word length is a parameter. A typical value is 32 bits times the number of chained devices.

Top module: `serial_loader`

## Requirements
- R1: During and after reset, and whenever the block is idle, `sclk_o`, `strobe_o`, `busy_o` and `done_o` are low.
- R2: A high `start_i` sampled while idle captures `word_i`, and `busy_o` is high from the next cycle. A load occupies exactly N_BITS*(SU+HI)+GAP+STB+1 cycles of `busy_o`.
- R3: Bit N_BITS-1 of the word is shifted first and bit 0 last. A receiving chain that shifts toward its far end therefore holds word bit i at stage i, and the first bit sits nearest the serial output.
- R4: Each load produces exactly N_BITS rising edges on `sclk_o` before the strobe.
- R5: Before every `sclk_o` rise, the clock is low for exactly SU = ceil(T_SETUP/T_SYS) cycles, and `sdata_o` has been stable for at least SU cycles.
- R6: `sclk_o` stays high for exactly HI = max(ceil(T_CLK_HIGH/T_SYS), ceil(T_HOLD/T_SYS)) cycles, and `sdata_o` does not change while it is high.
- R7: `strobe_o` rises exactly GAP = ceil(T_CLK_TO_STROBE/T_SYS) cycles after the final `sclk_o` fall, and `sclk_o` stays low while the strobe is high.
- R8: `strobe_o` stays high for exactly STB = ceil(T_STROBE/T_SYS) cycles.
- R9: `done_o` is high for a single cycle, immediately after `strobe_o` falls. `busy_o` is low on the following cycle.
- R10: A `start_i` asserted while `busy_o` is high, including during the `done_o` cycle, is ignored. No second load starts, and the latched word is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load request, sampled only when idle |
| word_i | input | N_BITS | Word to be loaded |
| sdata_o | output | 1 | Serial data to the driver chain |
| sclk_o | output | 1 | Shift clock to the driver chain |
| strobe_o | output | 1 | Latch strobe to the driver chain |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench models a receiving shift chain and latch. It checks the latched word against the word that was loaded, using asymmetric patterns and a single set bit. A reversed bit order or an off-by-one bit count would latch a mirrored or shifted word.

Every shift-clock low window, high window, strobe gap and strobe width is measured in cycles. A timer loaded with the wrong value would stretch or shorten one of these windows. Data that moved while the clock was high would break hold.

Start requests are injected mid-load and on the exact `done_o` cycle. A controller that accepted them would start a second strobe or leave `busy_o` high afterwards.

// File: rtl/loader_pkg.sv
package loader_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_CLK_HIGH,
    PH_GAP,
    PH_STROBE,
    PH_DONE
  } phase_e;

  // Minimum time in ps -> whole system cycles, rounded up, at least one.
  function automatic int unsigned cycles_for(input int unsigned t_ps,
                                             input int unsigned period_ps);
    int unsigned c;
    c = (t_ps + period_ps - 1) / period_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/loader_timer.sv
module loader_timer #(
  parameter int unsigned TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expired_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/loader_shifter.sv
module loader_shifter #(
  parameter int unsigned N_BITS = 32,
  localparam int unsigned CW = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [N_BITS-1:0] word_i,
  input  logic              advance_i,
  output logic              bit_o,
  output logic              last_o
);

  logic [N_BITS-1:0] sr_q;
  logic [CW-1:0]     left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (capture_i) begin
      sr_q   <= word_i;
      left_q <= CW'(N_BITS - 1);
    end else if (advance_i) begin
      sr_q   <= sr_q << 1;
      left_q <= left_q - 1'b1;
    end
  end

  // MSB leaves first
  assign bit_o  = sr_q[N_BITS-1];
  assign last_o = (left_q == '0);

endmodule

// File: rtl/serial_loader.sv
module serial_loader
  import loader_pkg::*;
#(
  parameter int unsigned N_BITS             = 32,
  parameter int unsigned SYS_PERIOD_PS      = 20000,
  parameter int unsigned T_SETUP_PS         = 25000,
  parameter int unsigned T_HOLD_PS          = 25000,
  parameter int unsigned T_CLK_HIGH_PS      = 50000,
  parameter int unsigned T_CLK_TO_STROBE_PS = 100000,
  parameter int unsigned T_STROBE_PS        = 50000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_BITS-1:0] word_i,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              strobe_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int unsigned SU_CYC  = cycles_for(T_SETUP_PS, SYS_PERIOD_PS);
  localparam int unsigned HI_CYC  = max_u(cycles_for(T_CLK_HIGH_PS, SYS_PERIOD_PS),
                                          cycles_for(T_HOLD_PS, SYS_PERIOD_PS));
  localparam int unsigned GAP_CYC = cycles_for(T_CLK_TO_STROBE_PS, SYS_PERIOD_PS);
  localparam int unsigned STB_CYC = cycles_for(T_STROBE_PS, SYS_PERIOD_PS);
  localparam int unsigned MAX_CYC = max_u(max_u(SU_CYC, HI_CYC), max_u(GAP_CYC, STB_CYC));
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);

  phase_e        phase_q, phase_d;
  logic          t_load, t_expired;
  logic [TW-1:0] t_val;
  logic          capture, advance, last_bit;
  logic          sclk_q, strobe_q, busy_q, done_q;

  loader_timer #(.TW(TW)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .expired_o  (t_expired)
  );

  loader_shifter #(.N_BITS(N_BITS)) i_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .word_i    (word_i),
    .advance_i (advance),
    .bit_o     (sdata_o),
    .last_o    (last_bit)
  );

  always_comb begin
    phase_d = phase_q;
    t_load  = 1'b0;
    t_val   = '0;
    capture = 1'b0;
    advance = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_SETUP;
        t_load  = 1'b1;
        t_val   = TW'(SU_CYC - 1);
        capture = 1'b1;
      end
      PH_SETUP: if (t_expired) begin
        phase_d = PH_CLK_HIGH;
        t_load  = 1'b1;
        t_val   = TW'(HI_CYC - 1);
      end
      PH_CLK_HIGH: if (t_expired) begin
        t_load = 1'b1;
        if (last_bit) begin
          phase_d = PH_GAP;
          t_val   = TW'(GAP_CYC - 1);
        end else begin
          // next bit is presented as the clock falls
          phase_d = PH_SETUP;
          t_val   = TW'(SU_CYC - 1);
          advance = 1'b1;
        end
      end
      PH_GAP: if (t_expired) begin
        phase_d = PH_STROBE;
        t_load  = 1'b1;
        t_val   = TW'(STB_CYC - 1);
      end
      PH_STROBE: if (t_expired) phase_d = PH_DONE;
      PH_DONE:   phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      sclk_q   <= 1'b0;
      strobe_q <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      sclk_q   <= (phase_d == PH_CLK_HIGH);
      strobe_q <= (phase_d == PH_STROBE);
      busy_q   <= (phase_d != PH_IDLE);
      done_q   <= (phase_d == PH_DONE);
    end
  end

  assign sclk_o   = sclk_q;
  assign strobe_o = strobe_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

endmodule

// File: rtl/serial_loader_chk.sv
module serial_loader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sdata_o,
  input logic sclk_o,
  input logic strobe_o,
  input logic busy_o,
  input logic done_o
);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !strobe_o && !done_o));

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> (sdata_o == $past(sdata_o)));

  p_no_clk_in_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> !sclk_o);

  p_done_after_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(strobe_o) && !strobe_o));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

endmodule

bind serial_loader serial_loader_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .sdata_o  (sdata_o),
  .sclk_o   (sclk_o),
  .strobe_o (strobe_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/test_serial_loader.sv
`timescale 1ns/1ps
module test_serial_loader;

  localparam int N       = 32;
  localparam int PER_PS  = 20000;
  localparam int SU      = (25000 + PER_PS - 1) / PER_PS;
  localparam int HI_A    = (50000 + PER_PS - 1) / PER_PS;
  localparam int HO      = (25000 + PER_PS - 1) / PER_PS;
  localparam int HI      = (HI_A > HO) ? HI_A : HO;
  localparam int GAP     = (100000 + PER_PS - 1) / PER_PS;
  localparam int STB     = (50000 + PER_PS - 1) / PER_PS;
  localparam int TOTAL   = N * (SU + HI) + GAP + STB + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0] word = '0;
  logic sdata, sclk, strobe, busy, done;

  int checks = 0, errors = 0, cycles = 0;

  serial_loader #(.N_BITS(N)) i_serial_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_i(word),
    .sdata_o(sdata), .sclk_o(sclk), .strobe_o(strobe), .busy_o(busy), .done_o(done)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // receiving chain model and timing monitor
  logic [N-1:0] rx = '0, latched = '0;
  logic prev_sclk = 0, prev_sdata = 0, prev_stb = 0;
  int low_cnt = 0, hi_cnt = 0, stb_cnt = 0, stable_cnt = 0;
  int rises = 0, strobes = 0, busy_cnt = 0;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(0, "WDOG", "watchdog expired", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (sclk && !prev_sclk) begin
        chk(low_cnt == SU, "R5", "clock low cycles before rise", low_cnt, SU);
        chk(stable_cnt >= SU, "R5", "data stable cycles before rise", stable_cnt, SU);
        chk(sdata == prev_sdata, "R5", "data moved at rise", sdata, prev_sdata);
        rx = {rx[N-2:0], sdata};
        rises++;
      end
      if (sclk && prev_sclk)
        chk(sdata == prev_sdata, "R6", "data moved while clock high", sdata, prev_sdata);
      if (!sclk && prev_sclk)
        chk(hi_cnt == HI, "R6", "clock high cycles", hi_cnt, HI);
      if (strobe && !prev_stb) begin
        chk(low_cnt == GAP, "R7", "gap from last clock fall", low_cnt, GAP);
        chk(rises == N, "R4", "clock rises per load", rises, N);
        latched = rx;
        strobes++;
      end
      if (strobe) chk(!sclk, "R7", "clock during strobe", sclk, 0);
      if (!strobe && prev_stb)
        chk(stb_cnt == STB, "R8", "strobe high cycles", stb_cnt, STB);
      if (done)
        chk(prev_stb && !strobe, "R9", "done not right after strobe fall", prev_stb, 1);
      if (busy) busy_cnt++;
    end
    hi_cnt     = sclk ? hi_cnt + 1 : 0;
    low_cnt    = (busy && !sclk && !strobe) ? low_cnt + 1 : 0;
    stb_cnt    = strobe ? stb_cnt + 1 : 0;
    stable_cnt = (sdata != prev_sdata) ? 1 : stable_cnt + 1;
    prev_sclk  = sclk;
    prev_sdata = sdata;
    prev_stb   = strobe;
  end

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < TOTAL + 20; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!sclk && !strobe && !busy && !done, "R1", "outputs in reset",
        {sclk, strobe, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sclk && !strobe && !busy && !done, "R1", "outputs when idle",
        {sclk, strobe, busy, done}, 0);
  endtask

  task automatic t_load(input logic [N-1:0] w);
    bit ok;
    int s0;
    s0 = strobes;
    rises = 0;
    busy_cnt = 0;
    @(negedge clk);
    word = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0; word = ~w;
    chk(busy, "R2", "busy after start", busy, 1);
    wait_done(ok);
    chk(ok, "R9", "done seen", ok, 1);
    chk(latched == w, "R3", "latched word", latched, w);
    chk(strobes == s0 + 1, "R8", "strobes per load", strobes - s0, 1);
    @(negedge clk);
    chk(!busy && !done, "R9", "idle after done", {busy, done}, 0);
    chk(busy_cnt == TOTAL, "R2", "busy cycles per load", busy_cnt, TOTAL);
  endtask

  task automatic t_ignore(input logic [N-1:0] a, input logic [N-1:0] b);
    bit ok;
    int s0;
    s0 = strobes;
    rises = 0;
    @(negedge clk);
    word = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (37) @(negedge clk);
    word = b; start = 1'b1;   // mid-load request
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < TOTAL + 20; i++) begin
      if (done) break;
      @(negedge clk);
    end
    ok = done;
    chk(ok, "R10", "done seen", ok, 1);
    start = 1'b1;             // request on the done cycle
    @(negedge clk);
    start = 1'b0;
    chk(!busy, "R10", "start on done cycle accepted", busy, 0);
    repeat (TOTAL / 2) @(negedge clk);
    chk(!busy, "R10", "busy after ignored start", busy, 0);
    chk(latched == a, "R10", "latched word after ignored starts", latched, a);
    chk(strobes == s0 + 1, "R10", "strobes after ignored starts", strobes - s0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_load(32'hA5C3_0F81);
    t_load(32'h0000_0001);
    t_load(32'h8000_0000);
    t_load('1);
    t_load('0);
    t_ignore(32'h1234_5678, 32'hFEDC_BA98);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule